// File: doc/BRIEF.md
# Parallel Flash Operation Status Responder

This block is a device-side model of the embedded program and erase controller in a byte-wide NOR-style flash. A host drives an asynchronous-style bus: chip select, read strobe and write strobe, all active low, plus an address and a write data byte. The block samples these pins on a system clock. A write strobe counts only after it has been held for a minimum number of consecutive clock samples. Each accepted write goes to a command decoder, which recognises unlock-prefixed program, sector erase, block erase and chip erase sequences.

Once a command is accepted, a busy timer runs for a fixed number of cycles set per operation, standing in for real array timing. During that time reads return polling status instead of array data. When the timer expires, the operation is applied to a small on-chip byte array. Erased bytes read as 0xFF. A program can only clear bits. The array is split into 16-byte sectors (address bits [8:4]) and 256-byte blocks (address bit [8]).

Top module: `flash_status_responder`

## Requirements
- R1: After reset, every array byte reads 0xFF, and dout is 0x00 when no read is in progress.
- R2: A bus write is accepted only when ce_n=0, we_n=0 and oe_n=1 have all held for FILT_N consecutive clock samples. Shorter pulses are ignored. A write with oe_n=0 is ignored. Each held strobe is accepted at most once.
- R3: The bytes 0xAA, 0x55, 0xA0 followed by an (address, data) write start a program. When it completes, the byte becomes old AND new.
- R4: While a program is busy, a read returns the inverse of bit 7 of the programmed data on dout[7], bit 6 inverts between successive reads, and dout[5:0] are 0.
- R5: While any erase is busy, a read returns 0 on dout[7].
- R6: 0xAA, 0x55, 0x80, 0xAA, 0x55, then 0x30 at an address erases only the 16-byte sector holding that address (addr[8:4] matches) to 0xFF.
- R7: The same prefix ending in 0x50 erases only the 256-byte block holding the address (addr[8] matches).
- R8: The same prefix ending in 0x10 erases the whole array. The sequence takes six accepted writes.
- R9: Writes accepted while an operation is busy are ignored. They neither start nor prepare a command.
- R10: A byte that does not fit the next step of a sequence returns the decoder to idle.
- R11: Busy lasts exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles for program, sector, block and chip erase respectively. After busy ends, reads return array data.
- R12: dout is 0x00 in the cycle after any sample with ce_n=1 or oe_n=1. Otherwise it shows the byte at addr, or the status byte while busy, one cycle after sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Registered read data or polling status |

## Verification
The busy countdown and the host's polling reads overlap. The final busy cycle, in which the array update commits, can coincide with a read that still has to return status. The very next read must then return the updated array byte. The bench holds a continuous read on the programmed address across the whole busy window. It also issues repeated short reads during erases. A behavioural reference model predicts dout on every clock, so a read that changes from status to data one cycle early or late is reported.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_BLK   = 8'h50;
endpackage

// File: rtl/flash_strobe_filter.sv
module flash_strobe_filter #(
    parameter int ADDR_W = 9,
    parameter int FILT_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int CNT_W = $clog2(FILT_N + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_N - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FILT_N);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              stb;
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } flt_t;

    flt_t f_q, f_d;
    logic wr_act;

    assign wr_act = !ce_n && !we_n && oe_n;

    always_comb begin
        f_d     = f_q;
        f_d.stb = 1'b0;
        if (wr_act) begin
            if (f_q.cnt == LAST) begin
                f_d.stb = 1'b1;
                f_d.a   = addr;
                f_d.d   = din;
            end
            if (f_q.cnt != FULL) f_d.cnt = f_q.cnt + 1'b1;
        end else begin
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign wr_stb  = f_q.stb;
    assign wr_addr = f_q.a;
    assign wr_data = f_q.d;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              go,
    output op_e               go_op,
    output logic [ADDR_W-1:0] go_addr,
    output logic [7:0]        go_data
);
    typedef enum logic [2:0] {
        S_IDLE, S_K1, S_K2, S_PDATA, S_E0, S_E1, S_E2
    } dec_e;

    typedef struct packed {
        dec_e st;
    } dec_t;

    dec_t s_q, s_d;

    always_comb begin
        s_d   = s_q;
        go    = 1'b0;
        go_op = OP_PROG;
        if (busy) begin
            s_d.st = S_IDLE;
        end else if (wr_stb) begin
            s_d.st = S_IDLE;
            case (s_q.st)
                S_IDLE:  if (wr_data == KEY_FIRST)  s_d.st = S_K1;
                S_K1:    if (wr_data == KEY_SECOND) s_d.st = S_K2;
                S_K2: begin
                    if (wr_data == CODE_PROG)       s_d.st = S_PDATA;
                    else if (wr_data == CODE_ERASE) s_d.st = S_E0;
                end
                S_PDATA: begin
                    go    = 1'b1;
                    go_op = OP_PROG;
                end
                S_E0:    if (wr_data == KEY_FIRST)  s_d.st = S_E1;
                S_E1:    if (wr_data == KEY_SECOND) s_d.st = S_E2;
                S_E2: begin
                    go = 1'b1;
                    if (wr_data == CODE_CHIP)      go_op = OP_CHIP;
                    else if (wr_data == CODE_SECT) go_op = OP_SECT;
                    else if (wr_data == CODE_BLK)  go_op = OP_BLK;
                    else                           go    = 1'b0;
                end
                default: s_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: S_IDLE};
        else        s_q <= s_d;
    end

    assign go_addr = wr_addr;
    assign go_data = wr_data;
endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SECT_W = 4,
    parameter int BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               op,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [7:0]        tdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (commit) begin
                case (op)
                    OP_PROG: if (GA == tgt) cell_d = cell_q & tdata;
                    OP_SECT: if (GA[ADDR_W-1:SECT_W] == tgt[ADDR_W-1:SECT_W]) cell_d = 8'hFF;
                    OP_BLK:  if (GA[ADDR_W-1:BLK_W] == tgt[ADDR_W-1:BLK_W]) cell_d = 8'hFF;
                    default: cell_d = 8'hFF;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= 8'hFF;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import flash_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int SECT_W   = 4,
    parameter int BLK_W    = 8,
    parameter int FILT_N   = 3,
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 80,
    parameter int BLK_CYC  = 120,
    parameter int CHIP_CYC = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout
);
    localparam int TW = $clog2(CHIP_CYC + 1);

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [TW-1:0]     cnt;
        logic [ADDR_W-1:0] tgt;
        logic [7:0]        tdata;
        logic              tog;
        logic              rd_prev;
        logic [7:0]        dout;
    } st_t;

    st_t st_q, st_d;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              go;
    op_e               go_op;
    logic [ADDR_W-1:0] go_addr;
    logic [7:0]        go_data;
    logic              commit;
    logic [7:0]        rd_data;
    logic              rd_act;
    logic              poll7;

    function automatic logic [TW-1:0] last_tick(op_e o);
        case (o)
            OP_PROG: return TW'(PROG_CYC - 1);
            OP_SECT: return TW'(SECT_CYC - 1);
            OP_BLK:  return TW'(BLK_CYC - 1);
            default: return TW'(CHIP_CYC - 1);
        endcase
    endfunction

    flash_strobe_filter #(.ADDR_W(ADDR_W), .FILT_N(FILT_N)) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_decoder (
        .clk(clk), .rst_n(rst_n), .busy(st_q.busy),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .go(go), .go_op(go_op), .go_addr(go_addr), .go_data(go_data)
    );

    flash_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(st_q.op),
        .tgt(st_q.tgt), .tdata(st_q.tdata),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign rd_act = !ce_n && !oe_n;
    assign poll7  = (st_q.op == OP_PROG) ? ~st_q.tdata[7] : 1'b0;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;

        st_d.dout = 8'h00;
        if (rd_act) begin
            if (st_q.busy) st_d.dout = {poll7, st_q.tog, 6'b000000};
            else           st_d.dout = rd_data;
        end

        st_d.rd_prev = rd_act;
        if (st_q.rd_prev && !rd_act && st_q.busy) st_d.tog = ~st_q.tog;

        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                commit    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (go) begin
            st_d.busy  = 1'b1;
            st_d.op    = go_op;
            st_d.tgt   = go_addr;
            st_d.tdata = go_data;
            st_d.cnt   = last_tick(go_op);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
endmodule

// File: rtl/flash_status_checker.sv
module flash_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic [7:0] dout,
    input logic       busy,
    input logic       is_prog,
    input logic       tdata7,
    input logic       cnt_zero,
    input logic       wr_stb
);
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (dout == 8'h00)); // R12

    AST_PROG_POLL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_prog && !ce_n && !oe_n) |=> (dout[7] == !$past(tdata7))); // R4

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n) |=> (dout[5:0] == 6'd0)); // R4

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_prog && !ce_n && !oe_n) |=> !dout[7]); // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnt_zero) |=> (busy && $stable(is_prog))); // R9

    AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ce_n && !we_n && oe_n)); // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2
endmodule

bind flash_status_responder flash_status_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dout     (dout),
    .busy     (st_q.busy),
    .is_prog  (st_q.op == flash_pkg::OP_PROG),
    .tdata7   (st_q.tdata[7]),
    .cnt_zero (st_q.cnt == '0),
    .wr_stb   (wr_stb)
);

// File: tb/flash_status_responder_tb.sv
module flash_status_responder_tb;
    localparam int AW    = 9;
    localparam int FN    = 3;
    localparam int T_PRG = 40;
    localparam int T_SEC = 80;
    localparam int T_BLK = 120;
    localparam int T_CHP = 160;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    ended  = 1'b0;
    string cur    = "R1";

    always #4 clk = ~clk;

    flash_status_responder #(
        .ADDR_W(AW), .SECT_W(4), .BLK_W(8), .FILT_N(FN),
        .PROG_CYC(T_PRG), .SECT_CYC(T_SEC), .BLK_CYC(T_BLK), .CHIP_CYC(T_CHP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout)
    );

    // behavioural reference model
    logic [7:0] mm [512];
    logic [7:0] exp_q = 8'h00;
    int         wrun, step, rem, m_op, m_a;
    bit         m_stb, m_busy, m_tog, m_prev;
    int         s_a;
    logic [7:0] s_d, m_d;
    int         pend[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
            exp_q = 8'h00; wrun = 0; step = 0; rem = 0; m_op = 0; m_a = 0;
            m_stb = 0; m_busy = 0; m_tog = 0; m_prev = 0; m_d = 0; s_a = 0; s_d = 0;
            pend.delete();
        end else begin
            bit rd, wa, was_busy;
            rd = !ce_n && !oe_n;
            wa = !ce_n && !we_n && oe_n;
            was_busy = m_busy;
            if (!rd)         exp_q = 8'h00;
            else if (m_busy) exp_q = {(m_op == 0) ? ~m_d[7] : 1'b0, m_tog, 6'b0};
            else             exp_q = mm[addr];
            if (m_prev && !rd && m_busy) m_tog = !m_tog;
            m_prev = rd;
            if (was_busy) begin
                step = 0;
                if (rem == 0) begin
                    m_busy = 0;
                    for (int i = 0; i < 512; i++) begin
                        if (m_op == 0 && i == m_a) mm[i] = mm[i] & m_d;
                        if (m_op == 1 && (i >> 4) == (m_a >> 4)) mm[i] = 8'hFF;
                        if (m_op == 2 && (i >> 8) == (m_a >> 8)) mm[i] = 8'hFF;
                        if (m_op == 3) mm[i] = 8'hFF;
                    end
                end else rem--;
            end else if (m_stb) begin
                pend.push_back(s_d);
                if (step == 3) begin
                    m_busy = 1; m_op = 0; m_a = s_a; m_d = s_d; rem = T_PRG - 1; step = 0;
                end else if (step == 6) begin
                    step = 0;
                    if (s_d == 8'h10)      begin m_busy = 1; m_op = 3; rem = T_CHP - 1; end
                    else if (s_d == 8'h30) begin m_busy = 1; m_op = 1; rem = T_SEC - 1; end
                    else if (s_d == 8'h50) begin m_busy = 1; m_op = 2; rem = T_BLK - 1; end
                    if (m_busy) begin m_a = s_a; m_d = s_d; end
                end else if (step == 0) step = (s_d == 8'hAA) ? 1 : 0;
                else if (step == 1)     step = (s_d == 8'h55) ? 2 : 0;
                else if (step == 2)     step = (s_d == 8'hA0) ? 3 : (s_d == 8'h80) ? 4 : 0;
                else if (step == 4)     step = (s_d == 8'hAA) ? 5 : 0;
                else                    step = (s_d == 8'h55) ? 6 : 0;
            end
            m_stb = wa && (wrun == FN - 1);
            if (m_stb) begin s_a = addr; s_d = din; end
            if (!wa) wrun = 0;
            else if (wrun < FN) wrun++;
        end
    end

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !ended) begin
            n_vec++;
            if (dout !== exp_q) begin
                n_bad++;
                $display("FAIL %s cycle compare: dout=%02h expected=%02h", cur, dout, exp_q);
            end
        end
    end

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", r, act, expv);
        end
    endtask

    task automatic bwrite(input logic [AW-1:0] a, input logic [7:0] d,
                          input int hold, input bit oe_low);
        ce_n = 0; we_n = 0; oe_n = oe_low ? 1'b0 : 1'b1; addr = a; din = d;
        repeat (hold) @(negedge clk);
        we_n = 1; ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        bwrite(a, d, FN + 1, 1'b0);
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [7:0] v);
        ce_n = 0; oe_n = 0; addr = a;
        @(negedge clk);
        v = dout;
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        wr(9'h000, 8'hAA); wr(9'h000, 8'h55); wr(9'h000, 8'hA0); wr(a, d);
    endtask

    task automatic erase(input logic [AW-1:0] a, input logic [7:0] code);
        wr(9'h000, 8'hAA); wr(9'h000, 8'h55); wr(9'h000, 8'h80);
        wr(9'h000, 8'hAA); wr(9'h000, 8'h55); wr(a, code);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, v2;
        ce_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0; rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(1);

        cur = "R1";
        chk("R1 idle dout", dout, 8'h00);
        bread(9'h000, v); chk("R1 erased low", v, 8'hFF);
        bread(9'h1FF, v); chk("R1 erased high", v, 8'hFF);

        cur = "R12";
        ce_n = 1; oe_n = 0; idle(2); chk("R12 ce high", dout, 8'h00);
        ce_n = 0; oe_n = 1; idle(2); chk("R12 oe high", dout, 8'h00);
        ce_n = 1; idle(1);

        cur = "R4";
        prog(9'h012, 8'h5A);
        bread(9'h012, v); bread(9'h012, v2);
        chk("R4 poll bit7", {7'd0, v[7]}, 8'h01);
        chk("R4 low bits", {2'b00, v[5:0]}, 8'h00);
        chk("R4 toggle", {7'd0, v2[6]}, {7'd0, ~v[6]});
        idle(T_PRG + 4);
        cur = "R3";
        bread(9'h012, v); chk("R3 program", v, 8'h5A);
        prog(9'h012, 8'hF0); idle(T_PRG + 4);
        bread(9'h012, v); chk("R3 and-merge", v, 8'h50);

        cur = "R9";
        prog(9'h020, 8'h0F);
        prog(9'h021, 8'h00);
        idle(T_PRG + 4);
        bread(9'h020, v); chk("R9 first op", v, 8'h0F);
        bread(9'h021, v); chk("R9 ignored while busy", v, 8'hFF);

        cur = "R6";
        erase(9'h015, 8'h30);
        bread(9'h015, v); chk("R5 sector poll", {7'd0, v[7]}, 8'h00);
        bread(9'h015, v2); chk("R5 sector toggle", {7'd0, v2[6]}, {7'd0, ~v[6]});
        idle(T_SEC + 4);
        bread(9'h012, v); chk("R6 sector erased", v, 8'hFF);
        bread(9'h020, v); chk("R6 neighbour kept", v, 8'h0F);

        cur = "R7";
        prog(9'h100, 8'h33); idle(T_PRG + 4);
        erase(9'h1A0, 8'h50);
        idle(T_BLK + 4);
        bread(9'h100, v); chk("R7 block erased", v, 8'hFF);
        bread(9'h020, v); chk("R7 other block kept", v, 8'h0F);

        cur = "R8";
        prog(9'h030, 8'h00); idle(T_PRG + 4);
        erase(9'h000, 8'h10);
        bread(9'h030, v); chk("R5 chip poll", {7'd0, v[7]}, 8'h00);
        idle(T_CHP + 4);
        bread(9'h020, v); chk("R8 chip erased a", v, 8'hFF);
        bread(9'h030, v); chk("R8 chip erased b", v, 8'hFF);

        cur = "R10";
        wr(9'h000, 8'hAA); wr(9'h000, 8'h55); wr(9'h000, 8'h77);
        wr(9'h000, 8'hA0); wr(9'h040, 8'h11);
        idle(T_PRG + 4);
        bread(9'h040, v); chk("R10 bad code", v, 8'hFF);
        wr(9'h000, 8'hAA); wr(9'h000, 8'h12); wr(9'h000, 8'h55);
        wr(9'h000, 8'hA0); wr(9'h041, 8'h22);
        idle(T_PRG + 4);
        bread(9'h041, v); chk("R10 bad key", v, 8'hFF);
        prog(9'h042, 8'h22); idle(T_PRG + 4);
        bread(9'h042, v); chk("R10 recovers", v, 8'h22);

        cur = "R2";
        bwrite(9'h000, 8'hAA, FN - 1, 1'b0);
        wr(9'h000, 8'h55); wr(9'h000, 8'hA0); wr(9'h043, 8'h00);
        idle(T_PRG + 4);
        bread(9'h043, v); chk("R2 short pulse", v, 8'hFF);
        bwrite(9'h000, 8'hAA, FN + 2, 1'b1);
        wr(9'h000, 8'h55); wr(9'h000, 8'hA0); wr(9'h044, 8'h00);
        idle(T_PRG + 4);
        bread(9'h044, v); chk("R2 oe low blocks", v, 8'hFF);
        bwrite(9'h000, 8'hAA, 4 * FN, 1'b0);
        wr(9'h000, 8'h55); wr(9'h000, 8'hA0); wr(9'h045, 8'h0C);
        idle(T_PRG + 4);
        bread(9'h045, v); chk("R2 long hold once", v, 8'h0C);

        cur = "R11";
        prog(9'h050, 8'h80);
        ce_n = 0; oe_n = 0; addr = 9'h050;
        idle(T_PRG + 6);
        chk("R11 data after busy", dout, 8'h80);
        ce_n = 1; oe_n = 1; idle(2);
        erase(9'h050, 8'h30);
        ce_n = 0; oe_n = 0; addr = 9'h050;
        idle(T_SEC + 6);
        chk("R11 sector end", dout, 8'hFF);
        ce_n = 1; oe_n = 1; idle(2);

        finish_run();
    end
endmodule